// File: doc/BRIEF.md
# SMBus Packet Error Code Checker

This block computes the SMBus packet error code over the byte stream of a transfer, and checks a received code against it. Bytes arrive one per accepted beat on a valid/ready input, together with a start-of-message marker and a marker that tags the byte as the packet error code. The CRC uses the 8-bit polynomial x^8 + x^2 + x + 1. It covers every message byte, and that includes each address byte with its read/write bit.

On transmit, the host logic reads the running CRC on `crc_out` after the last data byte and appends it as the final byte. On receive, the final byte is tagged with `in_pec`. The block compares that byte with the running value and raises a held pass or fail verdict. On a mismatch it also pulses a not-acknowledge request for that byte. A repeated start inside a message is not signalled at all: the bytes that follow simply continue the running CRC. Bit serialization and bus timing belong to the surrounding controller.

The back-pressure rules are simple because the block never stalls. `in_ready` is low while reset is applied and rises on the first clock after release. A beat transfers on any rising edge at which both `in_valid` and `in_ready` are high. While `in_valid` is low, the input fields are ignored.

Top module: `smbus_pec_checker`

## Requirements
- R1: After reset `crc_out` is 0x00, `pec_pass`, `pec_fail`, `pec_done` and `nack_req` are 0, and `in_ready` is 1 from the first clock after reset release.
- R2: For a non-PEC beat, the new CRC is the old value with the byte folded in MSB first using polynomial 0x07, with no reflection and no final XOR. As an example, the byte 0x01 after a start gives 0x07.
- R3: The whole byte is folded in within a single clock. `crc_out` shows the updated value in the cycle right after the accepted beat.
- R4: A beat with `in_som` set uses 0x00 as the starting CRC in place of the running value. Beats without it, including address bytes after a repeated start, keep accumulating.
- R5: Cycles with `in_valid` low change neither `crc_out` nor the verdict.
- R6: A beat with `in_pec` set is not folded in, so `crc_out` keeps its value. The byte is compared with the running CRC instead, or with 0x00 when `in_som` is also set.
- R7: On a matching PEC byte, `pec_pass` becomes 1 and `pec_fail` 0 in the following cycle. `pec_done` is 1 for exactly that one cycle.
- R8: On a mismatching PEC byte, `pec_fail` becomes 1 and `pec_pass` 0 in the following cycle. `nack_req` pulses high for that same single cycle, together with `pec_done`.
- R9: The verdict is held until the next accepted `in_som` beat, which clears both `pec_pass` and `pec_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte beat is offered |
| in_ready | output | 1 | Block accepts beats (high after reset) |
| in_data | input | 8 | Message byte, MSB processed first |
| in_som | input | 1 | First byte of a message; CRC restarts from 0x00 |
| in_pec | input | 1 | Byte is a received packet error code to be checked |
| crc_out | output | 8 | Running CRC over the bytes so far |
| pec_done | output | 1 | One-cycle pulse after a PEC byte was checked |
| pec_pass | output | 1 | Held: last PEC byte matched |
| pec_fail | output | 1 | Held: last PEC byte mismatched |
| nack_req | output | 1 | One-cycle not-acknowledge request for a bad PEC byte |

## Verification
Every one of the 256 byte values is sent as a lone byte after a start. This sweep separates a correct polynomial and bit order from reflected variants, variants with a final XOR, and wrong tap positions. All 256 candidate PEC values are then offered after a fixed message. Exactly one of them must pass, which exposes a comparator that is off by one bit or a comparison against the wrong value. Messages of varied length with a mid-message address byte and no start marker show whether the CRC is wrongly reset on a repeated start. Idle gaps between beats show that invalid cycles are ignored and that the verdict is held.

// File: rtl/smbus_pec_pkg.sv
package smbus_pec_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SMBUS_POLY = 8'h07;
  localparam logic [BYTE_W-1:0] SMBUS_INIT = 8'h00;

  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_PASS = 2'd1,
    VERDICT_FAIL = 2'd2
  } verdict_e;
endpackage

// File: rtl/pec_crc_fold.sv
module pec_crc_fold #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'h07
) (
  input  logic [W-1:0] crc_in,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] crc_next
);
  logic [W-1:0] stage [W+1];

  assign stage[0] = crc_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic fb;
    assign fb = stage[i][W-1] ^ data_in[W-1-i];
    assign stage[i+1] = {stage[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc_next = stage[W];
endmodule

// File: rtl/pec_crc_reg.sv
module pec_crc_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] INIT = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         beat,
  input  logic         som,
  input  logic         pec,
  input  logic [W-1:0] folded,
  output logic [W-1:0] base,
  output logic [W-1:0] crc_q
);
  assign base = som ? INIT : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
    end else if (beat && !pec) begin
      crc_q <= folded;
    end else if (beat && som) begin
      crc_q <= INIT;
    end
  end
endmodule

// File: rtl/pec_verdict.sv
module pec_verdict
  import smbus_pec_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         beat,
  input  logic         som,
  input  logic         pec,
  input  logic [W-1:0] data,
  input  logic [W-1:0] base,
  output logic         done,
  output logic         pass,
  output logic         fail,
  output logic         nack
);
  verdict_e state_q;
  logic     match;

  assign match = (data == base);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VERDICT_NONE;
      done    <= 1'b0;
      nack    <= 1'b0;
    end else begin
      done <= beat && pec;
      nack <= beat && pec && !match;
      if (beat && pec) begin
        state_q <= match ? VERDICT_PASS : VERDICT_FAIL;
      end else if (beat && som) begin
        state_q <= VERDICT_NONE;
      end
    end
  end

  assign pass = (state_q == VERDICT_PASS);
  assign fail = (state_q == VERDICT_FAIL);
endmodule

// File: rtl/smbus_pec_checker.sv
module smbus_pec_checker
  import smbus_pec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_som,
  input  logic              in_pec,
  output logic [BYTE_W-1:0] crc_out,
  output logic              pec_done,
  output logic              pec_pass,
  output logic              pec_fail,
  output logic              nack_req
);
  logic              beat;
  logic [BYTE_W-1:0] base;
  logic [BYTE_W-1:0] folded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign beat = in_valid && in_ready;

  pec_crc_fold #(.W(BYTE_W), .POLY(SMBUS_POLY)) i_fold (
    .crc_in  (base),
    .data_in (in_data),
    .crc_next(folded)
  );

  pec_crc_reg #(.W(BYTE_W), .INIT(SMBUS_INIT)) i_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .som   (in_som),
    .pec   (in_pec),
    .folded(folded),
    .base  (base),
    .crc_q (crc_out)
  );

  pec_verdict #(.W(BYTE_W)) i_verdict (
    .clk  (clk),
    .rst_n(rst_n),
    .beat (beat),
    .som  (in_som),
    .pec  (in_pec),
    .data (in_data),
    .base (base),
    .done (pec_done),
    .pass (pec_pass),
    .fail (pec_fail),
    .nack (nack_req)
  );
endmodule

// File: rtl/pec_checker.sv
module pec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_som,
  input logic       in_pec,
  input logic [7:0] crc_out,
  input logic       pec_done,
  input logic       pec_pass,
  input logic       pec_fail,
  input logic       nack_req
);
  // R7/R8: the verdict is never both pass and fail
  p_verdict_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pec_pass && pec_fail));

  // R8: a NACK request only accompanies a fresh failing verdict
  p_nack_with_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nack_req |-> (pec_fail && pec_done));

  // R7: done follows an accepted PEC beat
  p_done_after_pec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pec) |=> pec_done);

  // R5: idle cycles leave the CRC alone
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(crc_out));

  // R6: a PEC beat inside a message does not fold
  p_pec_no_fold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pec && !in_som) |=> $stable(crc_out));

  // R9: a start beat that is not a PEC clears the verdict
  p_som_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_som && !in_pec) |=> (!pec_pass && !pec_fail));
endmodule

bind smbus_pec_checker pec_checker i_pec_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_som  (in_som),
  .in_pec  (in_pec),
  .crc_out (crc_out),
  .pec_done(pec_done),
  .pec_pass(pec_pass),
  .pec_fail(pec_fail),
  .nack_req(nack_req)
);

// File: tb/test_smbus_pec_checker.sv
module test_smbus_pec_checker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_som = 1'b0;
  logic       in_pec = 1'b0;
  logic [7:0] crc_out;
  logic       pec_done, pec_pass, pec_fail, nack_req;

  int total = 0;
  int bad = 0;
  logic [7:0] model = 8'h00;
  logic [7:0] lfsr = 8'hA5;

  always #10 clk = ~clk;

  smbus_pec_checker i_smbus_pec_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_som(in_som), .in_pec(in_pec), .crc_out(crc_out),
    .pec_done(pec_done), .pec_pass(pec_pass), .pec_fail(pec_fail),
    .nack_req(nack_req)
  );

  // remainder of ((c ^ d) * x^8) modulo 0x107, by long division
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [15:0] v;
    v = {c ^ d, 8'h00};
    for (int b = 15; b >= 8; b--) begin
      if (v[b]) v = v ^ (16'h0107 << (b - 8));
    end
    return v[7:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive a beat at a falling edge; return at the next falling edge
  task automatic send(input logic [7:0] d, input logic som, input logic pec);
    in_valid = 1'b1; in_data = d; in_som = som; in_pec = pec;
    @(negedge clk);
    in_valid = 1'b0; in_som = 1'b0; in_pec = 1'b0; in_data = 8'h00;
  endtask

  task automatic next_rand(output logic [7:0] r);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    r = lfsr;
  endtask

  // fixed message: write address 0x16, command, two data bytes
  task automatic send_msg();
    logic [7:0] msg [4];
    msg[0] = 8'h16; msg[1] = 8'h3C; msg[2] = 8'hE1; msg[3] = 8'h5A;
    model = 8'h00;
    for (int i = 0; i < 4; i++) begin
      send(msg[i], i == 0, 1'b0);
      model = ref_crc(model, msg[i]);
    end
  endtask

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", in_ready, 1);
    check("R1 crc", crc_out, 8'h00);
    check("R1 verdict", {pec_done, pec_pass, pec_fail, nack_req}, 0);

    // R2/R3/R4: exhaustive single bytes after a start
    send(8'h01, 1'b1, 1'b0);
    check("R2 example 0x01", crc_out, 8'h07);
    for (int v = 0; v < 256; v++) begin
      send(v[7:0], 1'b1, 1'b0);
      check("R2 R3 R4 single byte", crc_out, ref_crc(8'h00, v[7:0]));
    end

    // R2/R4: two-byte sweep over a second byte after a nonzero start
    for (int v = 0; v < 256; v++) begin
      send(8'hA3, 1'b1, 1'b0);
      send(v[7:0], 1'b0, 1'b0);
      check("R2 two bytes", crc_out, ref_crc(ref_crc(8'h00, 8'hA3), v[7:0]));
    end

    // R5: idle cycles and ignored fields
    send(8'h5C, 1'b1, 1'b0);
    model = ref_crc(8'h00, 8'h5C);
    in_data = 8'hFF; in_som = 1'b1; in_pec = 1'b1;
    repeat (4) @(negedge clk);
    in_data = 8'h00; in_som = 1'b0; in_pec = 1'b0;
    check("R5 crc held over idle", crc_out, model);
    check("R5 no verdict from idle", {pec_done, pec_pass, pec_fail, nack_req}, 0);

    // R6/R7/R8/R9: all PEC candidates after a fixed message
    for (int p = 0; p < 256; p++) begin
      send_msg();
      check("R9 cleared by start", {pec_pass, pec_fail}, 0);
      send(p[7:0], 1'b0, 1'b1);
      check("R6 no fold", crc_out, model);
      if (p[7:0] == model) begin
        check("R7 pass", {pec_done, pec_pass, pec_fail, nack_req}, 4'b1100);
      end else begin
        check("R8 fail nack", {pec_done, pec_pass, pec_fail, nack_req}, 4'b1011);
      end
      @(negedge clk);
      check("R7 R8 done one cycle", {pec_done, nack_req}, 0);
      check("R9 held", {pec_pass, pec_fail}, (p[7:0] == model) ? 2'b10 : 2'b01);
    end

    // R4: repeated start continues; random lengths with read address mid-message
    for (int m = 0; m < 200; m++) begin
      logic [7:0] b;
      int len;
      next_rand(b);
      len = 1 + (b % 6);
      model = 8'h00;
      send(8'h16, 1'b1, 1'b0);
      model = ref_crc(model, 8'h16);
      for (int i = 0; i < len; i++) begin
        next_rand(b);
        send(b, 1'b0, 1'b0);
        model = ref_crc(model, b);
        if (b[0]) @(negedge clk);
      end
      send(8'h17, 1'b0, 1'b0);
      model = ref_crc(model, 8'h17);
      check("R4 repeated start continues", crc_out, model);
      send(m[0] ? model : (model ^ 8'h80), 1'b0, 1'b1);
      check("R7 R8 message verdict", {pec_pass, pec_fail, nack_req},
            m[0] ? 3'b100 : 3'b011);
    end

    // R6: PEC with start compares against 0x00
    send(8'h00, 1'b1, 1'b1);
    check("R6 lone PEC zero", {pec_pass, pec_fail, crc_out}, {2'b10, 8'h00});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule